// File: doc/BRIEF.md
# Fractional Bit-Clock Divider

This block turns the peripheral clock into a single-cycle enable pulse at sixteen times the serial bit rate. One pulse drives both the transmit and the receive shift logic. A 16-bit integer divisor sets the base spacing between pulses. A small fractional stage then stretches some of those spacings by one whole extra divisor period. As a result, the long-run pulse rate is `clk / (divisor * (1 + add/mul))`.

Software-facing registers reach the block as plain write strobes with a shared data byte. The divisor has a high byte and a low byte, and these can only be changed while the latch-access control input is high. The fractional byte holds a 4-bit add value and a 4-bit multiplier, and it can be written at any time. Settings that would stall or break the output are clamped instead of accepted as they are. An accepted divisor write restarts the pulse timing from a clean phase, so a new rate takes effect without a stray pulse.

No data stream crosses this block. Every pin is a plain control or status pin, so there is no valid/ready handshake and no back-pressure. Each write strobe is sampled for exactly the cycle it is high.

Top module: `frac_baud_gen`

## Requirements
- R1: While reset is low, `tick_o` is 0. Reset loads low byte 0x01, high byte 0x00, add 0 and multiplier 1. After reset is released, `tick_o` is therefore 1 on every cycle.
- R2: The effective divisor is `{high byte, low byte}`, with the high byte in bits 15:8 and the low byte in bits 7:0. With the fractional stage idle, pulses are exactly that many cycles apart.
- R3: `wr_div_lo_i` and `wr_div_hi_i` take effect only while `dlab_i` is 1. A strobe with `dlab_i` at 0 changes neither the rate nor the phase of `tick_o`.
- R4: `wr_frac_i` loads the add value from `wdata_i[3:0]` and the multiplier from `wdata_i[7:4]`, whatever the level of `dlab_i`.
- R5: Take D as the effective divisor, a as the effective add value and m as the effective multiplier. After a restart, the k-th pulse appears D*(k + floor(k*a/m)) cycles after the restarting write edge.
- R6: An effective add value of 0 turns the fractional stage off, so pulses are evenly spaced D cycles apart.
- R7: A multiplier field of 0 is used as 1.
- R8: An add value greater than or equal to the effective multiplier is used as multiplier minus 1.
- R9: When the effective add value is nonzero, the high byte is 0 and the low byte is below 2, the divisor used is 2. A divisor of 0 with the fractional stage idle is used as 1.
- R10: An accepted divisor-byte write restarts the timing. `tick_o` is 0 in the cycle after the write edge, and the fractional accumulator starts again from zero.
- R11: When the effective divisor is 2 or more, every pulse on `tick_o` lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dlab_i | input | 1 | Divisor latch access; enables divisor-byte writes |
| wr_div_lo_i | input | 1 | Write strobe for the divisor low byte |
| wr_div_hi_i | input | 1 | Write strobe for the divisor high byte |
| wr_frac_i | input | 1 | Write strobe for the add/multiplier byte |
| wdata_i | input | 8 | Write data shared by all strobes |
| tick_o | output | 1 | Single-cycle enable at 16x the bit rate |

## Verification
The bench sweeps every pair of multiplier and add value at low-byte settings 1 and 3, and checks `tick_o` on every cycle against the closed-form pulse schedule. This sweep covers the multiplier-zero clamp, the add-too-large clamp and the low-byte-2 floor. Any of these clamps left out would change the spacing or stall the output entirely, and either would show up as a pulse in the wrong cycle. A locked write in the middle of a run shows whether the latch gate is missing: a missing gate restarts the phase and shifts every later pulse. The same run checks the cycle right after each restart, where a design that kept the old phase would emit a pulse. A 256-cycle divisor checks that the high byte lands above the low byte.

// File: rtl/fbg_pkg.sv
package fbg_pkg;
  localparam int BYTE_W = 8;
  localparam int FRAC_W = BYTE_W / 2;
  localparam int DIV_W  = 2 * BYTE_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [FRAC_W-1:0] frac_t;
  typedef logic [DIV_W-1:0]  div_t;

  // Clamped configuration handed from the register stage to the timers.
  typedef struct packed {
    div_t  div;
    frac_t add;
    frac_t mul;
  } rate_cfg_t;
endpackage

// File: rtl/fbg_regs.sv
module fbg_regs
  import fbg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      dlab,
  input  logic      wr_lo,
  input  logic      wr_hi,
  input  logic      wr_frac,
  input  byte_t     wdata,
  output rate_cfg_t cfg,
  output logic      restart
);
  byte_t lo_q, hi_q;
  frac_t add_q, mul_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q  <= byte_t'(1);
      hi_q  <= '0;
      add_q <= '0;
      mul_q <= frac_t'(1);
    end else begin
      if (wr_lo && dlab) lo_q <= wdata;
      if (wr_hi && dlab) hi_q <= wdata;
      if (wr_frac) begin
        add_q <= wdata[FRAC_W-1:0];
        mul_q <= wdata[2*FRAC_W-1:FRAC_W];
      end
    end
  end

  frac_t mul_e, add_e;
  div_t  div_e;

  always_comb begin
    mul_e = (mul_q == '0) ? frac_t'(1) : mul_q;
    add_e = (add_q >= mul_e) ? (mul_e - frac_t'(1)) : add_q;
    div_e = {hi_q, lo_q};
    if (add_e != '0 && hi_q == '0 && lo_q < byte_t'(2))
      div_e = div_t'(2);
    else if (div_e == '0)
      div_e = div_t'(1);
  end

  assign cfg     = '{div: div_e, add: add_e, mul: mul_e};
  assign restart = dlab && (wr_lo || wr_hi);
endmodule

// File: rtl/fbg_div_cnt.sv
module fbg_div_cnt
  import fbg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  div_t div,
  output logic wrap
);
  div_t cnt_q;

  // ">=" keeps the counter from running away if the divisor shrinks mid-count.
  assign wrap = (cnt_q >= div - div_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || wrap) cnt_q <= '0;
    else                     cnt_q <= cnt_q + div_t'(1);
  end
endmodule

// File: rtl/fbg_frac_seq.sv
module fbg_frac_seq
  import fbg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  wrap,
  input  frac_t add,
  input  frac_t mul,
  output logic  tick
);
  frac_t           acc_q;
  logic            hold_q;
  logic            tick_q;
  logic [FRAC_W:0] sum;

  assign sum = {1'b0, acc_q} + {1'b0, add};

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q  <= '0;
      hold_q <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (wrap) begin
        if (hold_q) begin
          hold_q <= 1'b0;
          tick_q <= 1'b1;
        end else if (sum >= {1'b0, mul}) begin
          acc_q  <= FRAC_W'(sum - {1'b0, mul});
          hold_q <= 1'b1;
        end else begin
          acc_q  <= sum[FRAC_W-1:0];
          tick_q <= 1'b1;
        end
      end
    end
  end

  assign tick = tick_q;
endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
  import fbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dlab_i,
  input  logic              wr_div_lo_i,
  input  logic              wr_div_hi_i,
  input  logic              wr_frac_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              tick_o
);
  rate_cfg_t cfg;
  logic      restart;
  logic      wrap;

  fbg_regs u_regs (
    .clk(clk), .rst_n(rst_n), .dlab(dlab_i),
    .wr_lo(wr_div_lo_i), .wr_hi(wr_div_hi_i), .wr_frac(wr_frac_i),
    .wdata(wdata_i), .cfg(cfg), .restart(restart)
  );

  fbg_div_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .restart(restart), .div(cfg.div), .wrap(wrap)
  );

  fbg_frac_seq u_seq (
    .clk(clk), .rst_n(rst_n), .restart(restart), .wrap(wrap),
    .add(cfg.add), .mul(cfg.mul), .tick(tick_o)
  );
endmodule

// File: rtl/fbg_checker.sv
module fbg_checker
  import fbg_pkg::*;
(
  input logic      clk,
  input logic      rst_n,
  input logic      dlab,
  input logic      wr_lo,
  input logic      wr_hi,
  input logic      wr_frac,
  input logic      tick,
  input logic      restart,
  input rate_cfg_t cfg
);
  // R1: no pulse while reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |=> !tick);

  // R3: without an accepted write the clamped settings do not move
  a_r3_locked_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!(dlab && (wr_lo || wr_hi)) && !wr_frac) |=> $stable(cfg));

  // R8: add value stays below the multiplier
  a_r8_add_below_mul: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.add < cfg.mul);

  // R9: fractional stage active implies divisor of at least 2
  a_r9_div_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.add != '0) |-> (cfg.div >= div_t'(2)));

  // R10: a restart is followed by a quiet cycle
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick);

  // R11: single-cycle pulses once the divisor is 2 or more
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && cfg.div >= div_t'(2)) |=> !tick);
endmodule

bind frac_baud_gen fbg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dlab(dlab_i), .wr_lo(wr_div_lo_i),
  .wr_hi(wr_div_hi_i), .wr_frac(wr_frac_i), .tick(tick_o),
  .restart(restart), .cfg(cfg)
);

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dlab = 1'b0, wlo = 1'b0, whi = 1'b0, wfr = 1'b0;
  logic [7:0] wdata = '0;
  logic       tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  frac_baud_gen u_frac_baud_gen (
    .clk(clk), .rst_n(rst_n), .dlab_i(dlab), .wr_div_lo_i(wlo),
    .wr_div_hi_i(whi), .wr_frac_i(wfr), .wdata_i(wdata), .tick_o(tick)
  );

  task automatic check(input string req, input int act, input int exp, input int idx);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at index %0d: tick=%0d expected %0d", req, idx, act, exp);
    end
  endtask

  task automatic put(input logic l, input logic h, input logic f, input logic d, input logic [7:0] v);
    @(negedge clk);
    wlo = l; whi = h; wfr = f; dlab = d; wdata = v;
    @(posedge clk);
    @(negedge clk);
    wlo = 0; whi = 0; wfr = 0;
  endtask

  // Program one setting, then check tick on every cycle against the schedule.
  task automatic run(input int hi, input int lo, input int m, input int a,
                     input int lock_idx, input string req);
    int me = (m == 0) ? 1 : m;
    int ae = (a >= me) ? me - 1 : a;
    int d  = hi * 256 + lo;
    int k  = 1;
    int kmax = me + 1;
    int nxt;
    int last;
    if (ae != 0 && hi == 0 && lo < 2) d = 2;
    else if (d == 0) d = 1;
    nxt  = d * (1 + (ae / me));
    last = d * (kmax + (kmax * ae) / me);
    put(0, 0, 1, 0, 8'((m << 4) | a));          // R4 field positions
    put(0, 1, 0, 1, 8'(hi));
    put(1, 0, 0, 1, 8'(lo));                    // restart edge; now at index 0
    check("R10", int'(tick), 0, 0);
    for (int i = 1; i <= last; i++) begin
      @(negedge clk);
      if (i == nxt) begin
        check(req, int'(tick), 1, i);
        k++;
        nxt = d * (k + (k * ae) / me);
      end else begin
        check((d >= 2) ? "R11" : req, int'(tick), 0, i);
      end
      if (i == lock_idx) begin                  // R3 locked write
        dlab = 0; wlo = 1; whi = 1; wdata = 8'h07;
      end else begin
        wlo = 0; whi = 0;
      end
    end
  endtask

  initial begin
    #(190000 * 4);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(negedge clk);
    check("R1", int'(tick), 0, 0);
    rst_n = 1;
    repeat (4) begin
      @(negedge clk);
      check("R1", int'(tick), 1, 0);
    end
    run(1, 0, 1, 0, -1, "R2");
    run(0, 0, 1, 0, -1, "R9");
    run(0, 3, 4, 1, 5, "R3");
    run(0, 5, 5, 2, 7, "R3");
    for (int lo = 1; lo <= 3; lo += 2) begin
      for (int m = 0; m < 16; m++) begin
        for (int a = 0; a < 16; a++) begin
          if (m == 0) tag = "R7";
          else if (a >= m && a > 0) tag = "R8";
          else if (a > 0 && lo < 2) tag = "R9";
          else if (a == 0) tag = "R6";
          else tag = "R5";
          run(0, lo, m, a, -1, tag);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule